// File: doc/BRIEF.md
# Accuracy-Configurable Approximate Array Multiplier

This block multiplies two unsigned 8-bit operands and returns a 16-bit product. The partial products are summed by rows of adder cells, one ripple row per bit of the second operand. A 3-bit accuracy selector chooses, for each transaction, between exact operation and four approximation degrees. Each degree takes a fixed number of the lowest product columns out of exact arithmetic. A separate control bit decides what those columns do. Either every cell there becomes a cheap inexact adder, or the columns are tied to zero and pass no carries upward.

A small guard looks at the top two bits of both operands. If both operands are large, the error of any degree would be large too, so the guard overrides the selector, runs that transaction exactly and raises a flag. Operands, selector and control bit are sampled together when the input valid is high. Product, flag and output valid appear one clock later. The selector may change from one transaction to the next.

Top module: `apx_mult_top`

## Requirements
- R1: With selector code 0 and no guard hit, product equals op_a * op_b for every operand pair.
- R2: Selector codes 1, 2, 3 and 4 approximate the lowest 7, 8, 9 and 16 product columns respectively. Codes 5, 6 and 7 behave exactly like code 0.
- R3: Array structure: the accumulator starts as op_a & {8{op_b[0]}}. For row r = 1..7 a ripple of 8 cells covers columns r..r+7. Cell k takes a = accumulator bit at column r+k, b = op_a[k] & op_b[r], and cin = the carry from cell k-1 (0 for k = 0). Its sum replaces the accumulator bit, and the carry out of cell 7 becomes the accumulator bit at column r+8. With zero_tie = 0, a cell in an approximated column outputs sum = b and carry = a, and ignores cin. Every other cell is an exact full adder.
- R4: With zero_tie = 1 at a degree covering k columns, product bits k-1..0 read 0. The upper bits equal the exact sum of all partial-product terms op_a[i]·op_b[j]·2^(i+j) with i+j >= k. At degree 4 the product is therefore 0.
- R5: When op_a[7:6] and op_b[7:6] are both nonzero, guard_hit is 1 and the product is op_a * op_b, whatever the selector and zero_tie are. Otherwise guard_hit is 0.
- R6: Product and guard_hit for a transaction appear at the first rising edge after in_valid is sampled high. out_valid equals in_valid delayed by one clock.
- R7: While in_valid is low, product and guard_hit hold their previous values.
- R8: Synchronous active-low reset clears out_valid, product and guard_hit to 0.
- R9: Selector and zero_tie may differ on every consecutive transaction with no reset between them, and each result follows its own transaction's settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Transaction present on the inputs |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier (selects the rows) |
| mode | input | 3 | Accuracy selector: 0 exact, 1..4 degrees, 5..7 exact |
| zero_tie | input | 1 | 1 ties approximated columns to zero, 0 uses inexact cells |
| out_valid | output | 1 | Registered in_valid |
| product | output | 16 | Registered result |
| guard_hit | output | 1 | Registered guard override flag |

## Verification
Every result of this block is due one rising edge after its transaction is sampled: product, guard_hit and out_valid all come from one register stage. The bench drives each transaction on the falling edge. It then waits for the next rising edge and samples 1 ns after it, so each check sees exactly the register update caused by that transaction. The hold checks drive in_valid low with new operands and sample at the same point. They confirm that out_valid dropped and that product and guard_hit kept the values of the last valid transaction.

// File: rtl/apx_mult_pkg.sv
// Shared types for the approximate multiplier.
// Assumes a 3-bit accuracy selector; unlisted codes mean exact.
package apx_mult_pkg;

    typedef enum logic [2:0] {
        ACC_EXACT = 3'd0,
        ACC_DEG1  = 3'd1,
        ACC_DEG2  = 3'd2,
        ACC_DEG3  = 3'd3,
        ACC_DEG4  = 3'd4
    } acc_mode_e;

endpackage

// File: rtl/apx_cell.sv
// One adder cell of the multiplier array.
// Exact: full adder. Approximate: sum = b, carry = a, cin ignored.
// Approximate with zero tie: sum and carry are both 0.
// Assumes the caller decides per column whether the cell is approximated.
module apx_cell (
    input  logic a,
    input  logic b,
    input  logic cin,
    input  logic apx,
    input  logic zero_tie,
    output logic s,
    output logic co
);

    // Select the exact or inexact cell function.
    always_comb begin
        if (apx) begin
            if (zero_tie) begin
                s  = 1'b0;
                co = 1'b0;
            end else begin
                s  = b;
                co = a;
            end
        end else begin
            s  = a ^ b ^ cin;
            co = (a & b) | (a & cin) | (b & cin);
        end
    end

endmodule

// File: rtl/apx_guard.sv
// Operand guard: flags transactions whose top bits make approximation risky.
// Assumes unsigned operands; a hit means both operands have a set bit
// among their GB most significant bits.
module apx_guard #(
    parameter int W  = 8,
    parameter int GB = 2
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         hit
);

    // Both operands must be large for the guard to trip.
    always_comb begin
        hit = (|op_a[W-1 -: GB]) && (|op_b[W-1 -: GB]);
    end

endmodule

// File: rtl/apx_array.sv
// Row-ripple multiplier array with a column-count approximation knob.
// Row r adds op_a & op_b[r] at weight r into a 2W-bit accumulator.
// Cells in columns below ncols are approximated; with zero_tie those
// low product bits are also masked to zero at the output.
// Assumes ncols <= 2W.
module apx_array #(
    parameter int W  = 8,
    localparam int P  = 2 * W,
    localparam int CW = $clog2(P + 1)
) (
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [CW-1:0] ncols,
    input  logic          zero_tie,
    output logic [P-1:0]  prod
);

    logic [P-1:0] acc [W];
    logic [P-1:0] col_apx;
    logic [P-1:0] out_mask;

    // Per-column approximation select and zero-tie output mask.
    for (genvar c = 0; c < P; c++) begin : g_col
        assign col_apx[c]  = (ncols > CW'(c));
        assign out_mask[c] = zero_tie & col_apx[c];
    end

    // Row 0: the first partial product seeds the accumulator.
    assign acc[0] = {{W{1'b0}}, op_a & {W{op_b[0]}}};

    for (genvar r = 1; r < W; r++) begin : g_row
        logic [W:0] cy;
        assign cy[0] = 1'b0;

        // Ripple of W cells over columns r .. r+W-1.
        for (genvar k = 0; k < W; k++) begin : g_cell
            apx_cell u_cell (
                .a        (acc[r-1][r+k]),
                .b        (op_a[k] & op_b[r]),
                .cin      (cy[k]),
                .apx      (col_apx[r+k]),
                .zero_tie (zero_tie),
                .s        (acc[r][r+k]),
                .co       (cy[k+1])
            );
        end

        // Carry out of the row becomes the next accumulator column.
        assign acc[r][r+W] = cy[W];

        // Columns this row does not touch pass through.
        for (genvar j = 0; j < P; j++) begin : g_pass
            if (j < r || j > r + W) begin : g_keep
                assign acc[r][j] = acc[r-1][j];
            end
        end
    end

    // Final product with zero-tied columns forced low.
    assign prod = acc[W-1] & ~out_mask;

endmodule

// File: rtl/apx_mult_top.sv
// Accuracy-configurable approximate multiplier, one output register.
// Selector codes 1..4 approximate D1..D4_COLS low columns; other codes
// are exact. The guard forces exact operation for large operands.
// Assumes synchronous active-low reset; inputs sampled when in_valid.
module apx_mult_top #(
    parameter int W       = 8,
    parameter int GB      = 2,
    parameter int D1_COLS = 7,
    parameter int D2_COLS = 8,
    parameter int D3_COLS = 9,
    parameter int D4_COLS = 2 * W,
    localparam int P  = 2 * W,
    localparam int CW = $clog2(P + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   mode,
    input  logic         zero_tie,
    output logic         out_valid,
    output logic [P-1:0] product,
    output logic         guard_hit
);

    import apx_mult_pkg::*;

    logic          hit_c;
    acc_mode_e     eff_mode;
    logic [CW-1:0] ncols;
    logic [P-1:0]  prod_c;

    apx_guard #(.W(W), .GB(GB)) u_guard (
        .op_a (op_a),
        .op_b (op_b),
        .hit  (hit_c)
    );

    // Guard override: a hit turns any selector into exact.
    always_comb begin
        eff_mode = hit_c ? ACC_EXACT : acc_mode_e'(mode);
    end

    // Map the effective selector to a count of approximated columns.
    always_comb begin
        case (eff_mode)
            ACC_DEG1: ncols = CW'(D1_COLS);
            ACC_DEG2: ncols = CW'(D2_COLS);
            ACC_DEG3: ncols = CW'(D3_COLS);
            ACC_DEG4: ncols = CW'(D4_COLS);
            default:  ncols = '0;
        endcase
    end

    apx_array #(.W(W)) u_array (
        .op_a     (op_a),
        .op_b     (op_b),
        .ncols    (ncols),
        .zero_tie (zero_tie),
        .prod     (prod_c)
    );

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
            guard_hit <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                product   <= prod_c;
                guard_hit <= hit_c;
            end
        end
    end

    // R6: output valid tracks input valid one clock later.
    a_r6_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r6_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1: exact selector without guard gives the true product.
    a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd0) |=>
        product == P'($past(op_a)) * P'($past(op_b)));

    // R5: large operands raise the flag and get the exact product.
    a_r5_guard_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|op_a[W-1 -: GB]) && (|op_b[W-1 -: GB])) |=>
        (guard_hit && product == P'($past(op_a)) * P'($past(op_b))));

    // R4: zero tie at degree 1 leaves the low columns at zero.
    a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_tie && mode == 3'd1 &&
         !((|op_a[W-1 -: GB]) && (|op_b[W-1 -: GB]))) |=>
        ((product & ((P'(1) << D1_COLS) - P'(1))) == '0));

    // R7: outputs hold while no transaction is sampled.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(product) && $stable(guard_hit)));

    // R8: reset clears every output.
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0 && !guard_hit));

endmodule

// File: tb/apx_mult_top_tb.sv
`timescale 1ns/1ps
module apx_mult_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [2:0]  mode = '0;
    logic        zero_tie = 1'b0;
    logic        out_valid;
    logic [15:0] product;
    logic        guard_hit;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] last_prod;
    logic        last_hit;

    always #4 clk = ~clk;

    apx_mult_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
        .op_b(op_b), .mode(mode), .zero_tie(zero_tie),
        .out_valid(out_valid), .product(product), .guard_hit(guard_hit)
    );

    function automatic logic guard_of(input logic [7:0] a, input logic [7:0] b);
        return (|a[7:6]) && (|b[7:6]);
    endfunction

    function automatic int cols_of(input logic [2:0] m);
        case (m)
            3'd1: return 7;
            3'd2: return 8;
            3'd3: return 9;
            3'd4: return 16;
            default: return 0;
        endcase
    endfunction

    // Expected product per R1..R5.
    function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b,
                                             input logic [2:0] m, input logic zt);
        int cols;
        logic [15:0] acc;
        cols = guard_of(a, b) ? 0 : cols_of(m);
        if (cols == 0) return 16'(a) * 16'(b);
        acc = '0;
        if (zt) begin
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    if (i + j >= cols && a[i] && b[j]) acc = acc + (16'(1) << (i + j));
            return acc;
        end
        acc = {8'h00, a & {8{b[0]}}};
        for (int r = 1; r < 8; r++) begin
            logic c;
            c = 1'b0;
            for (int k = 0; k < 8; k++) begin
                logic x, y, s, co;
                x = acc[r+k];
                y = a[k] & b[r];
                if (r + k < cols) begin
                    s = y; co = x;
                end else begin
                    s = x ^ y ^ c; co = (x & y) | (x & c) | (y & c);
                end
                acc[r+k] = s;
                c = co;
            end
            acc[r+8] = c;
        end
        return acc;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One transaction: drive on falling edge, sample 1 ns after the rising edge.
    task automatic xact(input string tag, input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] m, input logic zt);
        logic [15:0] exp;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; mode = m; zero_tie = zt;
        exp = ref_prod(a, b, m, zt);
        @(posedge clk);
        #1;
        check(tag, "product", 32'(product), 32'(exp));
        check(guard_of(a, b) ? "R5" : tag, "guard_hit", 32'(guard_hit), 32'(guard_of(a, b)));
        check("R6", "out_valid", 32'(out_valid), 32'd1);
        last_prod = product;
        last_hit  = guard_hit;
    endtask

    // Idle cycle with changed inputs; outputs must hold (R7).
    task automatic idle_check(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b0; op_a = a; op_b = b; mode = 3'd4; zero_tie = 1'b1;
        @(posedge clk);
        #1;
        check("R6", "out_valid idle", 32'(out_valid), 32'd0);
        check("R7", "product held", 32'(product), 32'(last_prod));
        check("R7", "guard held", 32'(guard_hit), 32'(last_hit));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        // R8: reset clears outputs even with a transaction presented.
        in_valid = 1'b1; op_a = 8'hFF; op_b = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check("R8", "out_valid reset", 32'(out_valid), 32'd0);
        check("R8", "product reset", 32'(product), 32'd0);
        check("R8", "guard reset", 32'(guard_hit), 32'd0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;

        // R1: exhaustive exact mode.
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                xact("R1", 8'(a), 8'(b), 3'd0, 1'(b[0]));

        // R3 / R4: random operands in every degree and column behaviour.
        for (int m = 1; m <= 4; m++)
            for (int z = 0; z < 2; z++)
                for (int n = 0; n < 10000; n++)
                    xact(z ? "R4" : "R3", 8'($urandom_range(255)), 8'($urandom_range(255)),
                         3'(m), 1'(z));

        // R9 / R2: selector changing on every transaction, codes 0..7.
        for (int n = 0; n < 3000; n++)
            xact("R9", 8'($urandom_range(255)), 8'($urandom_range(255)),
                 3'($urandom_range(7)), 1'($urandom_range(1)));

        // R2: unused codes act as exact.
        for (int m = 5; m < 8; m++) begin
            xact("R2", 8'h3F, 8'h3F, 3'(m), 1'b1);
            check("R2", "code exact", 32'(last_prod), 32'h0F81);
        end
        // R2 / R4: degree 4 with zero tie clears all bits.
        xact("R4", 8'h3F, 8'h3F, 3'd4, 1'b1);
        check("R4", "deg4 zero", 32'(last_prod), 32'd0);
        // R5: guard overrides degree 4.
        xact("R5", 8'hC0, 8'h40, 3'd4, 1'b1);
        check("R5", "guard exact", 32'(last_prod), 32'h3000);
        xact("R5", 8'hFF, 8'hFF, 3'd3, 1'b0);
        // R5: guard idle when one operand is small.
        xact("R5", 8'h3F, 8'hFF, 3'd4, 1'b1);
        check("R5", "no guard", 32'(last_hit), 32'd0);
        // R7: hold across idle cycles.
        xact("R1", 8'hA5, 8'h5A, 3'd0, 1'b0);
        idle_check(8'h01, 8'h02);
        idle_check(8'hFF, 8'hFF);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule